// File: doc/BRIEF.md
# Variable-Latency Speculative Adder

This block is a clocked adder built on a segmented speculative core. The operand width is split into equal segments. Each segment predicts its carry-in from a small window of bits just below its boundary, so no carry has to travel the full width. Detection logic, built as its own stage, compares every predicted carry with the true carry across that boundary. A correction stage then adds the missing carry into the segments that were predicted wrongly. The correction stage works only when an error needs correcting. In every other cycle its result register keeps its value, which stands in for power gating.

When no correction is needed, the result is ready one cycle after the operands are accepted. When a correction runs, it is ready one cycle later. A mode input picks between two behaviours. In full correction, every faulty segment is fixed, so the output is always the exact sum. In configurable correction, only the lowest M segments may be fixed, counting upward from the least significant one. Faults above that range are left in place, and the result is flagged as inexact. Both sides use a valid/ready handshake, and the unit accepts one operand pair at a time.

Top module: `vlsa_adder`

## Requirements
- R1: After reset, out_valid and corr_en are 0 and in_ready is 1.
- R2: in_ready is 1 only while the unit is idle. An operand pair is taken only on a clock edge where in_valid and in_ready are both 1. Operands, mode and depth presented while the unit is busy have no effect on the result in flight.
- R3: If no segment inside the corrected range has a carry error, out_valid rises in the first cycle after the accepting edge.
- R4: If some segment inside the corrected range has a carry error, corr_en is 1 in the first cycle after the accepting edge, and out_valid rises in the second cycle.
- R5: With mode_full = 1, out_sum equals (in_a + in_b) mod 2^WIDTH, and out_exact is 1.
- R6: Segment i covers bits [i*SEG+SEG-1 : i*SEG]. Segment 0 has carry-in 0. For i ≥ 1, the predicted carry-in is the carry-out of adding the OVL operand bits directly below bit i*SEG, with a zero carry-in. An uncorrected segment outputs the sum of its operand bits plus the predicted carry, modulo 2^SEG.
- R7: With mode_full = 0, segments with index i < depth use the true carry-in. All other segments keep the predicted one.
- R8: A segment has an error when its predicted carry is 0 and its true carry is 1. With mode_full = 0 and depth = 0, nothing is corrected and the latency is always one cycle.
- R9: out_exact is 1 exactly when out_sum equals (in_a + in_b) mod 2^WIDTH.
- R10: corr_en is 1 only in a correction cycle. It never stays high for two cycles in a row, and it is never high while idle or while a result is being presented.
- R11: While out_valid = 1 and out_ready = 0, out_sum and out_exact hold steady. After an edge with out_valid and out_ready both 1, out_valid drops and in_ready returns to 1.
- R12: A depth value of at least the segment count behaves like full correction for that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair is valid |
| in_ready | output | 1 | Unit is idle and can take operands |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| mode_full | input | 1 | 1: correct all segments; 0: correct the lowest depth segments |
| depth | input | DW | Number of low segments to correct in configurable mode |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | WIDTH | Result, modulo 2^WIDTH |
| out_exact | output | 1 | Result equals the true sum |
| corr_en | output | 1 | Correction stage is enabled this cycle |

## Verification
The bench targets these cases:
- A ripple that crosses every boundary (0xFFFF + 1). If the design drops a boundary, its full-mode sum is wrong.
- A low window that generates a carry on its own. It must give a one-cycle result with no correction. A design that flags it spends an extra cycle.
- Depth values of 0, 1, a middle value and above the segment count. A mask that is off by one corrects the wrong segments, or takes the wrong latency.

Each operation's cycle count is compared with the count its error pattern implies. The value of corr_en in the cycle right after acceptance is checked too, which exposes a correction that is gated wrongly. Results are held back from the consumer while the bench keeps pushing new operands. A design that takes input while busy, or lets its output drift, returns the wrong sum.

// File: rtl/vlsa_pkg.sv
package vlsa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CORR = 2'd1,
    ST_OUT  = 2'd2
  } vlsa_state_e;

endpackage

// File: rtl/vlsa_spec_core.sv
module vlsa_spec_core #(
  parameter int WIDTH = 16,
  parameter int SEG   = 4,
  parameter int OVL   = 2,
  localparam int NSEG = WIDTH / SEG
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] spec_sum,
  output logic [NSEG-1:0]  spec_c,
  output logic [NSEG-1:0]  true_c
);

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    if (i == 0) begin : g_low
      assign spec_c[i] = 1'b0;
      assign true_c[i] = 1'b0;
    end else begin : g_hi
      localparam int LW = i * SEG;
      logic [LW:0] lo_sum;
      assign lo_sum    = {1'b0, a[LW-1:0]} + {1'b0, b[LW-1:0]};
      assign true_c[i] = lo_sum[LW];
      if (OVL > 0) begin : g_win
        logic [OVL:0] win_sum;
        assign win_sum   = {1'b0, a[LW-1 -: OVL]} + {1'b0, b[LW-1 -: OVL]};
        assign spec_c[i] = win_sum[OVL];
      end else begin : g_nowin
        assign spec_c[i] = 1'b0;
      end
    end
    assign spec_sum[i*SEG +: SEG] = a[i*SEG +: SEG] + b[i*SEG +: SEG]
                                  + {{(SEG-1){1'b0}}, spec_c[i]};
  end

endmodule

// File: rtl/vlsa_err_detect.sv
module vlsa_err_detect #(
  parameter int NSEG = 4,
  parameter int DW   = 3
) (
  input  logic [NSEG-1:0] spec_c,
  input  logic [NSEG-1:0] true_c,
  input  logic            full,
  input  logic [DW-1:0]   depth,
  output logic [NSEG-1:0] fix,
  output logic            need_corr,
  output logic            exact
);

  logic [NSEG-1:0] err;
  logic [NSEG-1:0] mask;

  for (genvar i = 0; i < NSEG; i++) begin : g_det
    assign err[i]  = true_c[i] & ~spec_c[i];
    assign mask[i] = full | (depth > DW'(i));
  end

  assign fix       = err & mask;
  assign need_corr = |fix;
  assign exact     = ~|(err & ~mask);

endmodule

// File: rtl/vlsa_corrector.sv
module vlsa_corrector #(
  parameter int WIDTH = 16,
  parameter int SEG   = 4,
  localparam int NSEG = WIDTH / SEG
) (
  input  logic [WIDTH-1:0] spec_sum,
  input  logic [NSEG-1:0]  fix,
  output logic [WIDTH-1:0] corr_sum
);

  for (genvar i = 0; i < NSEG; i++) begin : g_fix
    assign corr_sum[i*SEG +: SEG] = spec_sum[i*SEG +: SEG]
                                  + {{(SEG-1){1'b0}}, fix[i]};
  end

endmodule

// File: rtl/vlsa_adder.sv
module vlsa_adder #(
  parameter int WIDTH = 16,
  parameter int SEG   = 4,
  parameter int OVL   = 2,
  localparam int NSEG = WIDTH / SEG,
  localparam int DW   = $clog2(NSEG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             mode_full,
  input  logic [DW-1:0]    depth,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_exact,
  output logic             corr_en
);
  import vlsa_pkg::*;

  vlsa_state_e     state;
  logic [WIDTH-1:0] spec_sum;
  logic [NSEG-1:0]  spec_c;
  logic [NSEG-1:0]  true_c;
  logic [NSEG-1:0]  fix;
  logic             need_corr;
  logic             exact;
  logic [WIDTH-1:0] corr_sum;
  logic [WIDTH-1:0] res_sum;
  logic             res_exact;
  logic [NSEG-1:0]  fix_q;
  logic             full_q;
  logic             accept;

  vlsa_spec_core #(.WIDTH(WIDTH), .SEG(SEG), .OVL(OVL)) u_core (
    .a(in_a), .b(in_b), .spec_sum(spec_sum), .spec_c(spec_c), .true_c(true_c)
  );

  vlsa_err_detect #(.NSEG(NSEG), .DW(DW)) u_det (
    .spec_c(spec_c), .true_c(true_c), .full(mode_full), .depth(depth),
    .fix(fix), .need_corr(need_corr), .exact(exact)
  );

  vlsa_corrector #(.WIDTH(WIDTH), .SEG(SEG)) u_corr (
    .spec_sum(res_sum), .fix(fix_q), .corr_sum(corr_sum)
  );

  assign in_ready  = (state == ST_IDLE);
  assign accept    = in_valid & in_ready;
  assign corr_en   = (state == ST_CORR);
  assign out_valid = (state == ST_OUT);
  assign out_sum   = res_sum;
  assign out_exact = res_exact;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      res_sum   <= '0;
      res_exact <= 1'b0;
      fix_q     <= '0;
      full_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          res_sum   <= spec_sum;
          res_exact <= exact;
          fix_q     <= fix;
          full_q    <= mode_full;
          state     <= need_corr ? ST_CORR : ST_OUT;
        end
        ST_CORR: begin
          res_sum <= corr_sum;
          state   <= ST_OUT;
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vlsa_adder_chk.sv
module vlsa_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_sum,
  input logic             out_exact,
  input logic             corr_en,
  input logic             need_corr,
  input logic             full_q
);

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || corr_en) |-> !in_ready);

  assert_fast_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !need_corr) |=> (out_valid && !corr_en));

  assert_slow_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && need_corr) |=> (corr_en && !out_valid));

  assert_full_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && full_q) |-> out_exact);

  assert_corr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    corr_en |=> (!corr_en && out_valid));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_exact)));

  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

endmodule

bind vlsa_adder vlsa_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum),
  .out_exact(out_exact), .corr_en(corr_en), .need_corr(need_corr),
  .full_q(full_q)
);

// File: tb/vlsa_adder_bench.sv
`timescale 1ns/1ps
module vlsa_adder_bench;
  localparam int W = 16;
  localparam int S = 4;
  localparam int L = 2;
  localparam int NS = W / S;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic          mode_full = 1'b1;
  logic [2:0]    depth = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  out_sum;
  logic          out_exact;
  logic          corr_en;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vlsa_adder u_vlsa_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .mode_full(mode_full), .depth(depth),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum),
    .out_exact(out_exact), .corr_en(corr_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Restates the segment rules with plain integer arithmetic.
  function automatic void model(input int a, input int b, input bit full,
                                input int m, output int sum, output bit need);
    sum = 0;
    need = 1'b0;
    for (int i = 0; i < NS; i++) begin
      int tc, sc, c;
      bit fixed;
      tc = 0;
      sc = 0;
      if (i > 0) begin
        int lm;
        lm = (1 << (i * S)) - 1;
        tc = ((a & lm) + (b & lm)) >> (i * S);
        sc = (((a >> (i * S - L)) & 3) + ((b >> (i * S - L)) & 3)) >> L;
      end
      fixed = full || (i < m);
      if (fixed && tc != sc) need = 1'b1;
      c = fixed ? tc : sc;
      sum |= ((((a >> (i * S)) & 15) + ((b >> (i * S)) & 15) + c) & 15) << (i * S);
    end
  endfunction

  task automatic txn(input int a, input int b, input bit full, input int m,
                     input int hold);
    int exp_sum, lat, true_sum;
    bit need;
    logic [W-1:0] first_sum;
    model(a, b, full, m, exp_sum, need);
    true_sum = (a + b) & 16'hFFFF;
    @(negedge clk);
    check("R2 idle ready", int'(in_ready), 1);
    in_a = W'(a); in_b = W'(b); mode_full = full; depth = 3'(m);
    in_valid = 1'b1;
    out_ready = (hold == 0);
    @(posedge clk);
    @(negedge clk);
    // Busy: keep offering different operands, which must be ignored.
    in_a = ~W'(a); in_b = W'(b) ^ 16'h5A5A; mode_full = ~full; depth = 3'd0;
    lat = 1;
    check("R2 busy not ready", int'(in_ready), 0);
    check("R4/R10 corr_en after accept", int'(corr_en), int'(need));
    while (!out_valid && lat < 5) begin
      @(negedge clk);
      lat++;
    end
    check(need ? "R4 latency" : "R3 latency", lat, need ? 2 : 1);
    check("R10 corr_en off at output", int'(corr_en), 0);
    check("R6/R7 sum", int'(out_sum), exp_sum);
    check("R9 exact flag", int'(out_exact), int'(exp_sum == true_sum));
    if (full) check("R5 full exact", int'(out_sum), true_sum);
    first_sum = out_sum;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R11 held valid", int'(out_valid), 1);
      check("R11 held sum", int'(out_sum), int'(first_sum));
    end
    out_ready = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R11 release valid", int'(out_valid), 0);
    check("R11 release ready", int'(in_ready), 1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 out_valid reset", int'(out_valid), 0);
    check("R1 corr_en reset", int'(corr_en), 0);
    check("R1 in_ready reset", int'(in_ready), 1);
    rst_n = 1'b1;
    // Directed corner cases
    txn(16'h1234, 16'h1111, 1'b1, 0, 0);  // no carries
    txn(16'h000F, 16'h0001, 1'b1, 0, 0);  // error at boundary 1, R5
    txn(16'h000F, 16'h0001, 1'b0, 1, 0);  // R7 seg1 left uncorrected
    txn(16'h000F, 16'h0001, 1'b0, 2, 0);  // R7 seg1 corrected
    txn(16'h000F, 16'h0001, 1'b0, 0, 0);  // R8 depth zero
    txn(16'hFFFF, 16'h0001, 1'b1, 0, 0);  // ripple across all boundaries
    txn(16'hFFFF, 16'h0001, 1'b0, 3, 0);  // top segment left speculative
    txn(16'hFFFF, 16'h0001, 1'b0, 7, 0);  // R12 depth above segment count
    txn(16'hFFFF, 16'h0001, 1'b0, 4, 2);  // R12 plus output hold
    txn(16'h000C, 16'h0004, 1'b0, 0, 0);  // R6 window generates carry
    txn(16'h0FFF, 16'h0001, 1'b1, 0, 3);  // R11 hold on slow path
    // Random
    for (int k = 0; k < 300; k++) begin
      txn(int'($urandom_range(0, 16'hFFFF)), int'($urandom_range(0, 16'hFFFF)),
          1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
          int'($urandom_range(0, 3)) == 0 ? int'($urandom_range(1, 3)) : 0);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule